// File: doc/BRIEF.md
# Variable-Latency In-Order Instruction Pipeline

This block is a five-stage in-order pipeline that runs a short program of register-to-register arithmetic instructions held in its own instruction store. An instruction passes through fetch, decode, operand fetch, execute and writeback, in that order. Every stage except execute takes one cycle. The execute stage keeps an instruction for a number of cycles that depends on its opcode, and the three stages in front of it freeze while it does.

Results return to the 16-entry, 32-bit register file in the writeback stage. A result is also forwarded from the writeback stage to an operand fetch that needs it. An instruction whose source is being produced by the instruction currently in execute waits in operand fetch until that producer has left execute. During that wait a bubble enters execute.

The program and the initial register values are loaded through a shared load port while the block is idle. A start pulse then runs the first `n_instr` instructions. When the last instruction has been written back, the block raises `done` and freezes its cycle count and its retired-instruction count. The contents of the register file can be read at any time through a combinational read port.

Top module: `vlat_pipe`

## Requirements
- R1: An instruction spends one cycle in each of fetch, decode, operand fetch and writeback. A program of one single-cycle instruction ends with `cycles` = 5. The counter counts from the first fetch cycle through the writeback cycle of the last instruction.
- R2: Execute takes 1 cycle for ADD (opcode 00) and SUB (01), MUL_LAT = 3 cycles for MUL (10) and DIV_LAT = 6 cycles for DIV (11). For a program of n instructions with no dependencies, `cycles` = n + 4 + Σ(latency − 1).
- R3: While execute holds a multi-cycle instruction, the fetch, decode and operand-fetch registers and the fetch address keep their contents. Every instruction is executed exactly once and in program order, so the final register file matches sequential execution.
- R4: If either source register of the instruction in operand fetch equals the destination of the instruction in execute, operand fetch is held until the cycle after that producer's last execute cycle, and a bubble enters execute. Total cycles follow this rule exactly.
- R5: An operand whose producer is in writeback is taken from the writeback result rather than from the register file. A dependent instruction therefore reads the new value.
- R6: ADD and SUB wrap modulo 2^32. MUL keeps the low 32 bits of the product. DIV gives the truncated unsigned quotient, and all ones when the divisor is zero.
- R7: The instruction word has the opcode in bits [15:14], the destination in [11:8], source A in [7:4] and source B in [3:0]. The result is op(A, B). R0 is an ordinary register that can be written and read.
- R8: `done` rises in the cycle after the last writeback and `busy` falls at the same time. `cycles` and `retired` then hold their values until the next start, and `retired` equals `n_instr`.
- R9: A start with `n_instr` = 0 sets `done` at once, leaves `busy` low, and reads 0 on both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Load strobe, honoured only when idle |
| ld_rf | input | 1 | 1 = load a register, 0 = load an instruction word |
| ld_addr | input | IAW | Instruction index, or register number in bits [3:0] |
| ld_data | input | XLEN | Register value, or instruction word in bits [15:0] |
| start | input | 1 | Pulse to begin a run when idle |
| n_instr | input | IAW+1 | Number of instructions to run, sampled at start |
| rd_addr | input | 4 | Register read address |
| rd_data | output | XLEN | Register read data |
| busy | output | 1 | Program running |
| done | output | 1 | Last instruction written back |
| retired | output | IAW+1 | Instructions written back in this run |
| cycles | output | CW | Cycles in this run |

## Verification
The properties assume three things about the inputs. Loads and starts arrive only while `busy` is low. `n_instr` never exceeds the depth of the instruction store. Reset is applied before the first start. The stimulus loads the program and all 16 registers between runs, raises start only after `done` or reset, and draws program lengths from 1 to the store depth. The random programs often reuse the previous destination as a source, so that the held operand fetch and the forwarding path occur often, next to multi-cycle execute stalls.

// File: rtl/vlat_pipe.sv
module vlat_pipe #(
  parameter int XLEN       = 32,
  parameter int IMEM_DEPTH = 32,
  parameter int MUL_LAT    = 3,
  parameter int DIV_LAT    = 6,
  parameter int CW         = 16,
  localparam int IAW       = $clog2(IMEM_DEPTH),
  localparam int MAXLAT    = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT,
  localparam int LATW      = $clog2(MAXLAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic            ld_rf,
  input  logic [IAW-1:0]  ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic            start,
  input  logic [IAW:0]    n_instr,
  input  logic [3:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            busy,
  output logic            done,
  output logic [IAW:0]    retired,
  output logic [CW-1:0]   cycles
);

  logic [15:0]     imem [IMEM_DEPTH];
  logic [XLEN-1:0] rf   [16];

  logic [IAW:0]    pc, n_q;
  logic            fd_v, of_v, ex_v, wb_v;
  logic [15:0]     fd_ir, of_ir;
  logic [1:0]      ex_op;
  logic [3:0]      ex_rd, wb_rd;
  logic [XLEN-1:0] ex_a, ex_b, wb_res, alu;
  logic [LATW-1:0] ex_rem;

  wire [3:0] of_ra = of_ir[7:4];
  wire [3:0] of_rb = of_ir[3:0];

  wire ex_last  = ex_v && (ex_rem == LATW'(1));
  wire ex_hold  = ex_v && !ex_last;
  wire raw_hold = of_v && ex_v && (ex_rd == of_ra || ex_rd == of_rb);
  wire adv      = !ex_hold && !raw_hold;
  wire fetch    = busy && (pc < n_q);

  assign rd_data = rf[rd_addr];

  function automatic logic [LATW-1:0] lat_of(input logic [1:0] op);
    case (op)
      2'b10:   return LATW'(MUL_LAT);
      2'b11:   return LATW'(DIV_LAT);
      default: return LATW'(1);
    endcase
  endfunction

  function automatic logic [XLEN-1:0] opnd(input logic [3:0] r);
    return (wb_v && wb_rd == r) ? wb_res : rf[r];
  endfunction

  always_comb begin
    case (ex_op)
      2'b00:   alu = ex_a + ex_b;
      2'b01:   alu = ex_a - ex_b;
      2'b10:   alu = ex_a * ex_b;
      default: alu = (ex_b == '0) ? '1 : ex_a / ex_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_rf && !busy) imem[ld_addr] <= ld_data[15:0];
  end

  always_ff @(posedge clk) begin
    if (wb_v) rf[wb_rd] <= wb_res;
    else if (ld_we && ld_rf && !busy) rf[ld_addr[3:0]] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; pc <= '0; n_q <= '0;
      retired <= '0; cycles <= '0;
      fd_v <= 1'b0; of_v <= 1'b0; ex_v <= 1'b0; wb_v <= 1'b0;
      fd_ir <= '0; of_ir <= '0;
      ex_op <= '0; ex_rd <= '0; ex_a <= '0; ex_b <= '0; ex_rem <= '0;
      wb_rd <= '0; wb_res <= '0;
    end else if (start && !busy) begin
      busy    <= (n_instr != '0);
      done    <= (n_instr == '0);
      pc      <= '0;
      n_q     <= n_instr;
      retired <= '0;
      cycles  <= '0;
      fd_v <= 1'b0; of_v <= 1'b0; ex_v <= 1'b0; wb_v <= 1'b0;
    end else if (busy) begin
      cycles <= cycles + 1'b1;
      if (adv) begin
        fd_v  <= fetch;
        fd_ir <= imem[pc[IAW-1:0]];
        if (fetch) pc <= pc + 1'b1;
        of_v  <= fd_v;
        of_ir <= fd_ir;
      end
      if (ex_hold) begin
        ex_rem <= ex_rem - 1'b1;
      end else if (adv) begin
        ex_v   <= of_v;
        ex_op  <= of_ir[15:14];
        ex_rd  <= of_ir[11:8];
        ex_a   <= opnd(of_ra);
        ex_b   <= opnd(of_rb);
        ex_rem <= lat_of(of_ir[15:14]);
      end else begin
        ex_v <= 1'b0;
      end
      wb_v   <= ex_last;
      wb_rd  <= ex_rd;
      wb_res <= alu;
      if (wb_v) begin
        retired <= retired + 1'b1;
        if (retired + 1'b1 == n_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/vlat_pipe_chk.sv
module vlat_pipe_chk #(
  parameter int IAW  = 5,
  parameter int LATW = 3,
  parameter int CW   = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [CW-1:0]   cycles,
  input logic [IAW:0]    retired,
  input logic [IAW:0]    pc,
  input logic            fd_v,
  input logic [15:0]     fd_ir,
  input logic            of_v,
  input logic [15:0]     of_ir,
  input logic            ex_v,
  input logic [3:0]      ex_rd,
  input logic [LATW-1:0] ex_rem,
  input logic            wb_v
);

  p_front_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ex_v && ex_rem > LATW'(1) |=>
      $stable(pc) && $stable(fd_v) && $stable(fd_ir) && $stable(of_v) && $stable(of_ir));

  p_ex_countdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ex_v && ex_rem > LATW'(1) |=> ex_v && ex_rem == $past(ex_rem) - 1'b1);

  p_raw_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && of_v && ex_v && ex_rem == LATW'(1) &&
    (ex_rd == of_ir[7:4] || ex_rd == of_ir[3:0]) |=> !ex_v && $stable(of_ir) && of_v);

  p_wb_after_ex_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wb_v |-> $past(ex_v && ex_rem == LATW'(1)));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_count_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(cycles) && $stable(retired));

endmodule

bind vlat_pipe vlat_pipe_chk #(.IAW(IAW), .LATW(LATW), .CW(CW)) u_chk (.*);

// File: tb/test_vlat_pipe.sv
module test_vlat_pipe;
  localparam int XLEN = 32;
  localparam int DEPTH = 32;
  localparam int IAW = 5;
  localparam int CW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_we = 1'b0, ld_rf = 1'b0, start = 1'b0;
  logic [IAW-1:0]  ld_addr = '0;
  logic [XLEN-1:0] ld_data = '0;
  logic [IAW:0]    n_instr = '0;
  logic [3:0]      rd_addr = '0;
  logic [XLEN-1:0] rd_data;
  logic            busy, done;
  logic [IAW:0]    retired;
  logic [CW-1:0]   cycles;

  vlat_pipe i_vlat_pipe (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int p_op[DEPTH], p_rd[DEPTH], p_ra[DEPTH], p_rb[DEPTH];
  logic [31:0] ref_rf[16];

  task automatic chk(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lat(int op);
    return (op == 2) ? 3 : (op == 3) ? 6 : 1;
  endfunction

  function automatic logic [31:0] calc(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return (b == 0) ? 32'hFFFF_FFFF : a / b;
    endcase
  endfunction

  function automatic int ref_cycles(int n);
    int o = 0, x = 0;
    for (int i = 0; i < n; i++) begin
      if (i == 0) o = 3;
      else begin
        o = (o + 1 > x) ? o + 1 : x;
        if (p_rd[i-1] == p_ra[i] || p_rd[i-1] == p_rb[i])
          if (x + 1 > o) o = x + 1;
      end
      x = o + lat(p_op[i]);
    end
    return (n == 0) ? 0 : x + 1;
  endfunction

  task automatic set_instr(int i, int op, int rd, int ra, int rb);
    p_op[i] = op; p_rd[i] = rd; p_ra[i] = ra; p_rb[i] = rb;
  endtask

  task automatic load(logic sel, int addr, logic [31:0] data);
    ld_we = 1'b1; ld_rf = sel; ld_addr = IAW'(addr); ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic load_regs();
    for (int r = 0; r < 16; r++) load(1'b1, r, ref_rf[r]);
  endtask

  task automatic run(int n, string tag, int exp_cyc);
    logic [31:0] m[16];
    int waited = 0;
    for (int i = 0; i < n; i++)
      load(1'b0, i, {16'h0, 2'(p_op[i]), 2'b00, 4'(p_rd[i]), 4'(p_ra[i]), 4'(p_rb[i])});
    for (int r = 0; r < 16; r++) m[r] = ref_rf[r];
    for (int i = 0; i < n; i++) m[p_rd[i]] = calc(p_op[i], m[p_ra[i]], m[p_rb[i]]);
    n_instr = (IAW+1)'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
    if (!done) begin
      tests++; fails++;
      $display("FAIL R8 %s: done not seen, actual 0 expected 1", tag);
    end
    chk({"R1 R2 R4 cycles ", tag}, cycles, exp_cyc);
    chk({"R8 retired ", tag}, retired, n);
    chk({"R8 busy low ", tag}, busy, 0);
    for (int r = 0; r < 16; r++) begin
      rd_addr = 4'(r); #1;
      chk($sformatf("R3 R5 R6 reg %0d %s", r, tag), rd_data, m[r]);
      ref_rf[r] = m[r];
    end
    @(negedge clk);
    chk({"R8 frozen ", tag}, cycles, exp_cyc);
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset done", done, 0);
    chk("reset cycles", cycles, 0);
    chk("reset retired", retired, 0);

    for (int r = 0; r < 16; r++) ref_rf[r] = 32'(r * 7 + 3);
    load_regs();

    set_instr(0, 0, 3, 1, 2);
    run(1, "R1 single add", 5);

    set_instr(0, 2, 8, 1, 2); set_instr(1, 3, 9, 3, 4);
    set_instr(2, 0, 10, 5, 6); set_instr(3, 1, 11, 6, 7);
    run(4, "R2 independent mix", 4 + 4 + 2 + 5);

    set_instr(0, 2, 2, 0, 1); set_instr(1, 3, 5, 3, 4);
    set_instr(2, 0, 2, 5, 2); set_instr(3, 1, 5, 2, 6);
    run(4, "R4 R5 dependent chain", 17);

    ref_rf[1] = 32'hFFFF_FFF0; ref_rf[2] = 32'h0000_0020; ref_rf[4] = 32'h0;
    ref_rf[6] = 32'h8000_0001; ref_rf[7] = 32'd7;
    load_regs();
    set_instr(0, 0, 12, 1, 2); set_instr(1, 1, 13, 4, 7);
    set_instr(2, 2, 14, 6, 6); set_instr(3, 3, 15, 7, 4);
    set_instr(4, 3, 11, 1, 7);
    run(5, "R6 arithmetic edges", ref_cycles(5));
    rd_addr = 4'd15; #1;
    chk("R6 div by zero", rd_data, 32'hFFFF_FFFF);

    set_instr(0, 0, 0, 1, 2); set_instr(1, 1, 3, 0, 0); set_instr(2, 2, 0, 0, 3);
    run(3, "R7 r0 ordinary", ref_cycles(3));

    n_instr = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 empty done", done, 1);
    chk("R9 empty busy", busy, 0);
    chk("R9 empty cycles", cycles, 0);

    for (int k = 0; k < 40; k++) begin
      int n = (k == 0) ? DEPTH : 1 + int'($urandom % DEPTH);
      for (int r = 0; r < 16; r++)
        ref_rf[r] = ($urandom % 4 == 0) ? 32'($urandom % 8) : $urandom;
      load_regs();
      for (int i = 0; i < n; i++) begin
        int ra = int'($urandom % 16), rb = int'($urandom % 16);
        if (i > 0 && $urandom % 3 == 0) ra = p_rd[i-1];
        if (i > 0 && $urandom % 4 == 0) rb = p_rd[i-1];
        set_instr(i, int'($urandom % 4), int'($urandom % 16), ra, rb);
      end
      run(n, $sformatf("R3 random %0d", k), ref_cycles(n));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule